// File: doc/BRIEF.md
# SLC-96 Receive Multiframe Message Extractor

This block sits behind the framing-bit recovery of a T1 receiver running in D4 superframe mode. For every received frame it is given a strobe, the recovered framing bit, and a flag that says whether that frame is in an Fs slot or an Ft slot. Ft-slot bits are ignored. The Fs-slot bits form a stream of 36 bits per 72-frame multiframe, which is six back-to-back 12-frame superframes.

Twelve of those 36 positions carry a fixed alignment word. The other 24 positions carry the concentrator, maintenance, alarm and spoiler fields. The extractor searches the Fs stream for the alignment word and declares lock. At every multiframe boundary where the alignment word is intact, it copies the message positions into three byte-wide registers and raises a sticky flag. The registers then stay unchanged for a whole multiframe, about 9 ms, so that software can read them at leisure before the next load.

The alignment positions, the alignment value and the loss threshold are parameters. The extractor runs only while its D4-mode enable is high.

Top module: `slc_rx_extract`

## Requirements
- R1: After reset, `locked` and `updFlag` are 0 and all three message registers are 0.
- R2: A cycle without `frameStb`, or a strobed frame with `fsPos` = 0 (Ft slot), leaves the lock state, the Fs position count, the message registers and the flag unchanged. The one exception is the flag clear described in R7.
- R3: While unlocked, once at least 36 Fs bits have been received, lock is declared on the Fs frame whose bit completes a 36-bit window in which every alignment position holds the alignment value. The window is indexed 0 (oldest) to 35 (newest). With the default parameters the alignment positions are 0–5, holding 0,0,1,1,1,0, and 30–35, holding 1,0,0,0,1,1.
- R4: Once locked, every 36th Fs bit closes a multiframe. If the closing window matches the alignment word, the message registers load and the flag sets on the same clock edge that registers that frame.
- R5: The message bits are the non-alignment window positions, taken in ascending order and packed from bit 0 of `msgReg0` upward through `msgReg1` and `msgReg2`. Register bits left unused read 0. With the defaults, positions 6–13 go to `msgReg0`, 14–21 to `msgReg1` and 22–29 to `msgReg2`.
- R6: The message registers change only at a load. A multiframe with an alignment mismatch leaves them as they were.
- R7: `updFlag` is sticky and is cleared by a one-cycle `updClr` pulse. If a clear and a load occur in the same cycle, the flag ends up set.
- R8: The flag is never set by a multiframe whose alignment word fails to match.
- R9: A single mismatched multiframe keeps lock. Two consecutive mismatched multiframes drop `locked` on the edge that closes the second one.
- R10: While `enable` is low, `locked` is 0 and Fs bits are not collected. After `enable` returns high, a full new 36-bit window must be gathered before lock can be declared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | D4 mode with cross-coupled Ft/Fs sync selected |
| frameStb | input | 1 | One-cycle pulse per received frame |
| fsPos | input | 1 | 1 when the strobed frame is an Fs slot |
| fBit | input | 1 | Received framing bit, valid with `frameStb` |
| updClr | input | 1 | One-cycle clear for `updFlag` |
| locked | output | 1 | Multiframe alignment lock |
| updFlag | output | 1 | Sticky new-message indication |
| msgReg0 | output | REG_W | Message bits 0..7 |
| msgReg1 | output | REG_W | Message bits 8..15 |
| msgReg2 | output | REG_W | Message bits 16..23 |

## Verification
The hardest case to reach is the lock-loss path. Reaching it requires a locked receiver to see two alignment failures in a row, at multiframe boundaries that the receiver itself chose, with a good multiframe in between in some runs. The stimulus deals with this in two steps. First it runs a bench-side model of the Fs window, which tracks where the design's boundaries fall even when the lock was acquired after a misaligned preamble. Second, it corrupts one alignment bit in whole generated multiframes in the patterns bad–good and bad–bad. The same-cycle clear-and-load case is produced by pulsing the clear on the closing Fs frame of a multiframe.

// File: rtl/slc_rx_pkg.sv
package slc_rx_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftEn;  // shift the received Fs bit into the window
    logic loadMsg;  // publish message bits and set the update flag
  } ctlStrobes_t;

endpackage

// File: rtl/slc_rx_control.sv
module slc_rx_control
  import slc_rx_pkg::*;
#(
  parameter int FS_N       = 36,
  parameter int MISS_LIMIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        frameStb,
  input  logic        fsPos,
  input  logic        alignNext,
  output ctlStrobes_t strb,
  output logic        locked
);

  localparam int IDX_W  = $clog2(FS_N);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FS_N - 1);
  localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(MISS_LIMIT - 1);

  logic              fsEvt;
  logic [IDX_W-1:0]  fsIdx, fillCnt;
  logic [MISS_W-1:0] missCnt;
  logic              filled, atBoundary;

  assign fsEvt      = frameStb & fsPos & enable;
  assign filled     = (fillCnt == LAST_IDX);
  assign atBoundary = (fsIdx == LAST_IDX);

  // strobes toward the datapath
  always_comb begin
    strb.shiftEn = fsEvt;
    strb.loadMsg = 1'b0;
    if (fsEvt) begin
      if (!locked) strb.loadMsg = filled & alignNext;
      else         strb.loadMsg = atBoundary & alignNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked  <= 1'b0;
      fsIdx   <= '0;
      fillCnt <= '0;
      missCnt <= '0;
    end else if (!enable) begin
      locked  <= 1'b0;
      fsIdx   <= '0;
      fillCnt <= '0;
      missCnt <= '0;
    end else if (fsEvt) begin
      if (!locked) begin
        if (filled && alignNext) begin
          locked  <= 1'b1;
          fsIdx   <= '0;
          missCnt <= '0;
        end else if (!filled) begin
          fillCnt <= fillCnt + 1'b1;
        end
      end else if (atBoundary) begin
        fsIdx <= '0;
        if (alignNext) begin
          missCnt <= '0;
        end else if (missCnt == LAST_MISS) begin
          locked  <= 1'b0;
          missCnt <= '0;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end else begin
        fsIdx <= fsIdx + 1'b1;
      end
    end
  end

  // R8: a load is only ever requested on a matching window
  p_load_needs_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMsg |-> alignNext);

  // R3: lock rises only on a matching Fs frame
  p_lock_rise_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(fsEvt) && $past(alignNext)));

  // R2: without an Fs event the lock state holds
  p_ft_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(frameStb && fsPos)) |=> ($stable(locked) && $stable(fsIdx)));

  // R4: position counter stays inside one multiframe
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    fsIdx <= LAST_IDX);

  // R10: disabled extractor is never locked
  p_disable_unlock_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !locked);

endmodule

// File: rtl/slc_rx_datapath.sv
module slc_rx_datapath
  import slc_rx_pkg::*;
#(
  parameter int               FS_N       = 36,
  parameter int               REG_W      = 8,
  parameter logic [FS_N-1:0]  ALIGN_MASK = 36'hFC000003F,
  parameter logic [FS_N-1:0]  ALIGN_PAT  = 36'hC4000001C
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic             fBit,
  input  logic             updClr,
  output logic             alignNext,
  output logic [REG_W-1:0] msgReg0,
  output logic [REG_W-1:0] msgReg1,
  output logic [REG_W-1:0] msgReg2,
  output logic             updFlag
);

  localparam int MSG_W = 3 * REG_W;

  logic [FS_N-2:0] win;      // older Fs bits, index 0 oldest
  logic [FS_N-1:0] winNext;  // window including the bit on the input now
  logic [MSG_W-1:0] msgNext;

  function automatic logic [MSG_W-1:0] packMsg(input logic [FS_N-1:0] w);
    logic [MSG_W-1:0] o;
    int k;
    o = '0;
    k = 0;
    for (int i = 0; i < FS_N; i++) begin
      if (!ALIGN_MASK[i]) begin
        if (k < MSG_W) o[k] = w[i];
        k++;
      end
    end
    return o;
  endfunction

  assign winNext   = {fBit, win};
  assign alignNext = (((winNext ^ ALIGN_PAT) & ALIGN_MASK) == '0);
  assign msgNext   = packMsg(winNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) win <= '0;
    else if (strb.shiftEn) win <= winNext[FS_N-1:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgReg0 <= '0;
      msgReg1 <= '0;
      msgReg2 <= '0;
    end else if (strb.loadMsg) begin
      msgReg0 <= msgNext[REG_W-1:0];
      msgReg1 <= msgNext[2*REG_W-1:REG_W];
      msgReg2 <= msgNext[3*REG_W-1:2*REG_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             updFlag <= 1'b0;
    else if (strb.loadMsg) updFlag <= 1'b1;
    else if (updClr)       updFlag <= 1'b0;
  end

  // R6: registers hold unless a load is strobed
  p_hold_regs_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMsg |=> ($stable(msgReg0) && $stable(msgReg1) && $stable(msgReg2)));

  // R7: set beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMsg |=> updFlag);

  // R7: a lone clear empties the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (updClr && !strb.loadMsg) |=> !updFlag);

endmodule

// File: rtl/slc_rx_extract.sv
module slc_rx_extract
  import slc_rx_pkg::*;
#(
  parameter int               FS_N       = 36,
  parameter int               REG_W      = 8,
  parameter int               MISS_LIMIT = 2,
  parameter logic [FS_N-1:0]  ALIGN_MASK = 36'hFC000003F,
  parameter logic [FS_N-1:0]  ALIGN_PAT  = 36'hC4000001C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             frameStb,
  input  logic             fsPos,
  input  logic             fBit,
  input  logic             updClr,
  output logic             locked,
  output logic             updFlag,
  output logic [REG_W-1:0] msgReg0,
  output logic [REG_W-1:0] msgReg1,
  output logic [REG_W-1:0] msgReg2
);

  ctlStrobes_t strb;
  logic        alignNext;

  slc_rx_control #(
    .FS_N(FS_N), .MISS_LIMIT(MISS_LIMIT)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .frameStb(frameStb),
    .fsPos(fsPos), .alignNext(alignNext), .strb(strb), .locked(locked)
  );

  slc_rx_datapath #(
    .FS_N(FS_N), .REG_W(REG_W), .ALIGN_MASK(ALIGN_MASK), .ALIGN_PAT(ALIGN_PAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fBit(fBit), .updClr(updClr),
    .alignNext(alignNext), .msgReg0(msgReg0), .msgReg1(msgReg1),
    .msgReg2(msgReg2), .updFlag(updFlag)
  );

  // R8: a fresh flag always comes with lock
  p_flag_rise_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> locked);

endmodule

// File: tb/slc_rx_extract_tb_top.sv
`timescale 1ns/1ps
module slc_rx_extract_tb_top;

  localparam logic [35:0] B_MASK = 36'hFC000003F;
  localparam logic [35:0] B_PAT  = 36'hC4000001C;

  typedef struct {
    logic       lk;
    logic       fl;
    logic [7:0] r0, r1, r2;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic frameStb = 1'b0, fsPos = 1'b0, fBit = 1'b0, updClr = 1'b0;
  logic locked, updFlag;
  logic [7:0] msgReg0, msgReg1, msgReg2;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // bench model state
  logic        mLock = 0, mFlag = 0;
  int          mIdx = 0, mFill = 0, mMiss = 0;
  logic [35:0] mHist = '0;
  logic [7:0]  mR0 = 0, mR1 = 0, mR2 = 0;

  always #2 clk = ~clk;

  slc_rx_extract dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .frameStb(frameStb),
    .fsPos(fsPos), .fBit(fBit), .updClr(updClr), .locked(locked),
    .updFlag(updFlag), .msgReg0(msgReg0), .msgReg1(msgReg1), .msgReg2(msgReg2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input string tag);
    exp_t e;
    e.lk = mLock; e.fl = mFlag; e.r0 = mR0; e.r1 = mR1; e.r2 = mR2; e.tag = tag;
    q.push_back(e);
  endtask

  // one registered step of the expected behaviour (R2..R10)
  task automatic modelStep(input logic stb, input logic fsp, input logic b, input logic clr);
    logic [35:0] hn;
    logic al, ld;
    ld = 1'b0;
    if (!enable) begin
      mLock = 0; mIdx = 0; mFill = 0; mMiss = 0;
    end else if (stb && fsp) begin
      hn = {b, mHist[35:1]};
      al = (((hn ^ B_PAT) & B_MASK) == '0);
      if (!mLock) begin
        if (mFill == 35 && al) begin mLock = 1; mIdx = 0; mMiss = 0; ld = 1; end
        else if (mFill < 35) mFill++;
      end else if (mIdx == 35) begin
        mIdx = 0;
        if (al) begin ld = 1; mMiss = 0; end
        else if (mMiss == 1) begin mLock = 0; mMiss = 0; end
        else mMiss++;
      end else mIdx++;
      mHist = hn;
      if (ld) begin
        mR0 = hn[13:6]; mR1 = hn[21:14]; mR2 = hn[29:22];
      end
    end
    if (ld) mFlag = 1;
    else if (clr) mFlag = 0;
  endtask

  task automatic frame(input logic fsp, input logic b, input logic clr, input string tag);
    @(negedge clk);
    frameStb = 1; fsPos = fsp; fBit = b; updClr = clr;
    @(posedge clk); #1;
    modelStep(1'b1, fsp, b, clr);
    pushExp(tag);
    @(negedge clk);
    frameStb = 0; updClr = 0; fBit = ~b; fsPos = ~fsp;
    @(negedge clk);
    pushExp("R2 idle hold");
  endtask

  task automatic clrOnly();
    @(negedge clk);
    updClr = 1;
    @(posedge clk); #1;
    modelStep(1'b0, 1'b0, 1'b0, 1'b1);
    pushExp("R7 clear");
    @(negedge clk);
    updClr = 0;
  endtask

  // 36 Fs bits of one multiframe, built from the requirement's layout
  function automatic logic [35:0] mfBits(input logic [23:0] msg, input bit bad);
    logic [35:0] v;
    v = '0;
    v[5:0]   = 6'b011100;   // positions 0..5 hold 0,0,1,1,1,0
    v[35:30] = 6'b110001;   // positions 30..35 hold 1,0,0,0,1,1
    v[29:6]  = msg;
    if (bad) v[3] = ~v[3];
    return v;
  endfunction

  task automatic sendMf(input logic [23:0] msg, input bit bad, input bit clrEnd, input string tag);
    logic [35:0] v;
    v = mfBits(msg, bad);
    for (int j = 0; j < 72; j++) begin
      if (j[0]) frame(1'b1, v[j/2], (clrEnd && j == 71), tag);
      else      frame(1'b0, j[1], 1'b0, "R2 Ft frame");
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " locked"}, {31'd0, locked}, {31'd0, e.lk});
        check({e.tag, " flag"},   {31'd0, updFlag}, {31'd0, e.fl});
        check({e.tag, " regs"},   {8'd0, msgReg2, msgReg1, msgReg0}, {8'd0, e.r2, e.r1, e.r0});
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 locked", {31'd0, locked}, 0);
    check("R1 flag", {31'd0, updFlag}, 0);
    check("R1 regs", {8'd0, msgReg2, msgReg1, msgReg0}, 0);
    rstN = 1; enable = 1;
    @(negedge clk);
    // misaligned preamble of seven Fs bits
    for (int k = 0; k < 7; k++) begin
      frame(1'b0, 1'b1, 1'b0, "R2 Ft frame");
      frame(1'b1, k[0] ^ k[2], 1'b0, "R3 hunt");
    end
    sendMf(24'h5A3C81, 0, 0, "R3 hunt");
    sendMf(24'h129F6E, 0, 0, "R4 update");
    @(negedge clk);
    // R5 direct packing check against generated data
    check("R5 msgReg0", {24'd0, msgReg0}, 32'h6E);
    check("R5 msgReg1", {24'd0, msgReg1}, 32'h9F);
    check("R5 msgReg2", {24'd0, msgReg2}, 32'h12);
    check("R3 locked", {31'd0, locked}, 1);
    clrOnly();
    sendMf(24'hC0FFEE, 0, 1, "R7 set wins");
    check("R7 set wins flag", {31'd0, updFlag}, 1);
    clrOnly();
    sendMf(24'h333333, 1, 0, "R6 R8 single miss");
    check("R9 single miss keeps lock", {31'd0, locked}, 1);
    check("R8 no flag on miss", {31'd0, updFlag}, 0);
    check("R6 regs hold", {8'd0, msgReg2, msgReg1, msgReg0}, 32'h00C0FFEE);
    sendMf(24'h0A0B0C, 0, 0, "R4 recover");
    sendMf(24'h777777, 1, 0, "R9 miss one");
    sendMf(24'h888888, 1, 0, "R9 miss two");
    check("R9 lock lost", {31'd0, locked}, 0);
    sendMf(24'h246801, 0, 0, "R3 relock");
    sendMf(24'h13579B, 0, 0, "R4 relocked");
    @(negedge clk);
    enable = 0;
    for (int k = 0; k < 10; k++) frame(k[0], 1'b1, 1'b0, "R10 disabled");
    check("R10 unlocked", {31'd0, locked}, 0);
    enable = 1;
    sendMf(24'hFEDCBA, 0, 0, "R10 refill");
    sendMf(24'hABCDEF, 0, 0, "R10 relock");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule